// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a register-mapped timer with a parameterised number of channels, two or four. Each channel holds a 64-bit interval and a 64-bit down-counter. The counter advances at a rate set by a per-channel power-of-two divider of the bus clock. A channel either restarts from its interval each time it runs out, or stops after running out once. Each expiry sets a sticky pending flag. A shared enable mask passes that flag to the channel's own interrupt line.

Software reaches every register through one synchronous write port and a combinational read port with 8-bit byte addresses. Changes to a channel's run bit do not act at once. They pass through a short synchroniser, so software that stops a channel and reprograms it must allow for a settling delay of two clocks. A separate self-clearing request bit copies the interval into the counter on the channel's next tick, whether the channel is running or not.

Top module: `dct_top`

## Requirements
- R1: After reset every register reads zero and every interrupt line is low.
- R2: Registers sit at byte offsets 0x00 (interrupt enable, bit n for channel n), 0x04 (pending flags) and, for channel n, 0x20*n plus 0x10 (control), 0x14 (interval low), 0x18 (interval high), 0x1C (count low) and 0x20 (count high). Control holds run in bit 0, load request in bit 1, divider select in bits 6:4 and single-shot in bit 7. Unmapped offsets, and enable bits above the channel count, read zero.
- R3: Writing 1 to control bit 1 copies the interval into the counter on the channel's next tick, whether or not the channel runs. The bit then reads 0.
- R4: While running, the counter drops by one per tick and otherwise holds its value. A channel loaded with all ones reads a falling value.
- R5: A divider select p gives one tick every 2^p clocks. A tick falls on the edges where the low p bits of a free-running clock count are all ones.
- R6: When a running channel ticks at zero it expires, sets its pending flag and reloads its interval. Successive expiries are therefore (I+1)*2^p clocks apart for interval I.
- R7: In single-shot mode an expiry clears control bit 0. The counter then stays at zero and no further expiry follows.
- R8: A run-bit value written at clock edge k governs counting from edge k+3 on. Edges k+1 and k+2 still follow the previous value.
- R9: Writing 1 to bit n of 0x04 clears channel n's flag, and writing 0 leaves it unchanged. An expiry in the same cycle as a clear wins.
- R10: Interrupt line n is high exactly while flag n and enable bit n are both set.
- R11: Channels count, expire and load independently of each other.
- R12: The interval and the counter are 64 bits wide, exposed as low and high 32-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, sampled at the rising edge |
| addr | input | 8 | Byte address for read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irq | output | NUM_CH | Per-channel interrupt lines |

## Verification
A write lands at the edge that samples it. Reads are combinational, so the bench samples every value at the falling edge after the edge it targets. A load request shows in the counter one edge after the write, and with p=0 the first decrement follows at the third edge, as R8 requires. After a stop write, the counter is read again at the second and tenth falling edges to confirm that exactly two more decrements occurred. Expiry periods are measured between two interrupt rises with a rising-edge counter, which makes the measurement independent of the divider's phase. Every (interval, divider) pair chosen gives at least three clocks between expiries, so the clear write always fits in between.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int PRE_W  = 7;   // 2^3 divider selects, largest divides by 2^7

  // configuration strobes from register file to counting datapath
  typedef struct packed {
    logic       enable;
    logic       reloadPend;
    logic       oneShot;
    logic [2:0] presc;
  } chCfg_t;

  // events from datapath back to register file
  typedef struct packed {
    logic expire;
    logic reloadDone;
  } chEvt_t;

  localparam int SLOT_CTRL  = 0;
  localparam int SLOT_IV_LO = 1;
  localparam int SLOT_IV_HI = 2;
  localparam int SLOT_CN_LO = 3;
  localparam int SLOT_CN_HI = 4;

  function automatic logic [ADDR_W-1:0] regOff(input int ch, input int slot);
    return ADDR_W'(32 * ch + 16 + 4 * slot);
  endfunction
endpackage

// File: rtl/dct_regs.sv
module dct_regs
  import dct_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wrData,
  output logic [DATA_W-1:0]             rdData,
  output chCfg_t [NUM_CH-1:0]           cfg,
  output logic [NUM_CH-1:0][CNT_W-1:0]  interval,
  input  chEvt_t [NUM_CH-1:0]           evt,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cnt,
  output logic [NUM_CH-1:0]             status,
  output logic [NUM_CH-1:0]             intEn
);
  localparam int HI_W = CNT_W - DATA_W;

  logic wrIe, wrSt;
  assign wrIe = wrEn && (addr == ADDR_W'(0));
  assign wrSt = wrEn && (addr == ADDR_W'(4));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEn  <= '0;
      status <= '0;
    end else begin
      if (wrIe) intEn <= wrData[NUM_CH-1:0];
      for (int n = 0; n < NUM_CH; n++) begin
        status[n] <= (status[n] & ~(wrSt & wrData[n])) | evt[n].expire;
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic wrCtl, wrLo, wrHi;
    assign wrCtl = wrEn && (addr == regOff(g, SLOT_CTRL));
    assign wrLo  = wrEn && (addr == regOff(g, SLOT_IV_LO));
    assign wrHi  = wrEn && (addr == regOff(g, SLOT_IV_HI));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfg[g]      <= '0;
        interval[g] <= '0;
      end else begin
        if (wrCtl) begin
          cfg[g].enable     <= wrData[0];
          cfg[g].reloadPend <= wrData[1] | (cfg[g].reloadPend & ~evt[g].reloadDone);
          cfg[g].presc      <= wrData[6:4];
          cfg[g].oneShot    <= wrData[7];
        end else begin
          if (evt[g].reloadDone) cfg[g].reloadPend <= 1'b0;
          if (evt[g].expire && cfg[g].oneShot) cfg[g].enable <= 1'b0;
        end
        if (wrLo) interval[g][DATA_W-1:0]     <= wrData;
        if (wrHi) interval[g][CNT_W-1:DATA_W] <= wrData[HI_W-1:0];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(0)) rdData[NUM_CH-1:0] = intEn;
    if (addr == ADDR_W'(4)) rdData[NUM_CH-1:0] = status;
    for (int n = 0; n < NUM_CH; n++) begin
      if (addr == regOff(n, SLOT_CTRL))
        rdData = {24'd0, cfg[n].oneShot, cfg[n].presc, 2'b00, cfg[n].reloadPend, cfg[n].enable};
      if (addr == regOff(n, SLOT_IV_LO)) rdData = interval[n][DATA_W-1:0];
      if (addr == regOff(n, SLOT_IV_HI)) rdData = DATA_W'(interval[n][CNT_W-1:DATA_W]);
      if (addr == regOff(n, SLOT_CN_LO)) rdData = cnt[n][DATA_W-1:0];
      if (addr == regOff(n, SLOT_CN_HI)) rdData = DATA_W'(cnt[n][CNT_W-1:DATA_W]);
    end
  end
endmodule

// File: rtl/dct_core.sv
module dct_core
  import dct_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int CNT_W       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  chCfg_t [NUM_CH-1:0]           cfg,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  interval,
  output chEvt_t [NUM_CH-1:0]           evt,
  output logic [NUM_CH-1:0]             run,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cnt
);
  logic [PRE_W-1:0] preCnt;

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic [PRE_W-1:0]       mask;
    logic                   tick, atZero, expire, loadNow;
    logic [SYNC_STAGES-1:0] enSync;

    assign mask    = ~({PRE_W{1'b1}} << cfg[g].presc);
    assign tick    = (preCnt & mask) == mask;
    assign atZero  = (cnt[g] == '0);
    assign loadNow = tick & cfg[g].reloadPend;
    assign expire  = tick & run[g] & ~cfg[g].reloadPend & atZero;
    assign evt[g]  = '{expire: expire, reloadDone: loadNow};
    assign run[g]  = enSync[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
      if (!rstN)                        enSync <= '0;
      else if (expire && cfg[g].oneShot) enSync <= '0;
      else                              enSync <= {enSync[SYNC_STAGES-2:0], cfg[g].enable};
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt[g] <= '0;
      end else if (loadNow) begin
        cnt[g] <= interval[g];
      end else if (tick && run[g]) begin
        if (!atZero)              cnt[g] <= cnt[g] - 1'b1;
        else if (!cfg[g].oneShot) cnt[g] <= interval[g];
      end
    end
  end
endmodule

// File: rtl/dct_top.sv
module dct_top
  import dct_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [7:0]          addr,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  output logic [NUM_CH-1:0]   irq
);
  chCfg_t [NUM_CH-1:0]           chCfg;
  chEvt_t [NUM_CH-1:0]           chEvt;
  logic [NUM_CH-1:0][CNT_W-1:0]  ivVal;
  logic [NUM_CH-1:0][CNT_W-1:0]  cntVal;
  logic [NUM_CH-1:0]             chRun;
  logic [NUM_CH-1:0]             intStat;
  logic [NUM_CH-1:0]             intEn;

  dct_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .cfg(chCfg), .interval(ivVal), .evt(chEvt),
    .cnt(cntVal), .status(intStat), .intEn(intEn)
  );

  dct_core #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .SYNC_STAGES(2)) uCore (
    .clk(clk), .rstN(rstN), .cfg(chCfg), .interval(ivVal),
    .evt(chEvt), .run(chRun), .cnt(cntVal)
  );

  assign irq = intStat & intEn;
endmodule

// File: rtl/dct_checker.sv
module dct_checker
  import dct_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 64
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          wrEn,
  input chCfg_t [NUM_CH-1:0]           cfg,
  input chEvt_t [NUM_CH-1:0]           evt,
  input logic [NUM_CH-1:0]             run,
  input logic [NUM_CH-1:0]             status,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0]  interval
);
  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    // R8
    ena_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(run[g]) |-> $past(cfg[g].enable, 2));
    // R7
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (evt[g].expire && cfg[g].oneShot && !wrEn) |=> !cfg[g].enable);
    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      evt[g].expire |=> status[g]);
    // R3
    reload_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      evt[g].reloadDone |=> (cnt[g] == $past(interval[g])));
    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!run[g] && !evt[g].reloadDone) |=> $stable(cnt[g]));
  end
endmodule

bind dct_top dct_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chkInst (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .cfg(chCfg), .evt(chEvt),
  .run(chRun), .status(intStat), .cnt(cntVal), .interval(ivVal)
);

// File: tb/dct_top_test.sv
module dct_top_test;
  localparam int NUM_CH = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [7:0]        addr = '0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;
  logic [NUM_CH-1:0] irq;

  int checks = 0;
  int fails  = 0;
  int edgeCnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  dct_top #(.NUM_CH(NUM_CH)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  function automatic logic [7:0] off(input int ch, input int slot);
    return 8'(32 * ch + 16 + 4 * slot);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitIrq(input int ch, output int t);
    int k = 0;
    while (!irq[ch] && k < 5000) begin
      @(negedge clk);
      k++;
    end
    t = edgeCnt;
  endtask

  task automatic measPeriod(input int ch, input int p, input int iv);
    int t1, t2;
    wr(off(ch, 0), 32'h0);
    repeat (4) @(negedge clk);
    wr(8'h04, 32'(1 << ch));
    wr(off(ch, 1), 32'(iv));
    wr(off(ch, 2), 32'h0);
    wr(off(ch, 0), 32'((p << 4) | 3));
    waitIrq(ch, t1);
    wr(8'h04, 32'(1 << ch));
    waitIrq(ch, t2);
    // R5 R6 period (I+1)*2^p
    chk($sformatf("R5_R6 ch%0d p=%0d I=%0d", ch, p, iv), 64'(t2 - t1), 64'((iv + 1) << p));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a <= 8'h50; a += 4) begin
      rd(8'(a), v);
      chk($sformatf("R1 addr %0h", a), 64'(v), 64'h0);
    end
    chk("R1 irq", 64'(irq), 64'h0);

    // R2 register map readback
    wr(off(1, 1), 32'hA5A5_1234);
    rd(off(1, 1), v); chk("R2 ivlo ch1", 64'(v), 64'hA5A5_1234);
    wr(off(1, 0), 32'h70);
    rd(off(1, 0), v); chk("R2 ctrl ch1", 64'(v), 64'h70);
    wr(8'h00, 32'hFF);
    rd(8'h00, v); chk("R2 ie mask width", 64'(v), 64'h3);
    rd(8'h08, v); chk("R2 unmapped", 64'(v), 64'h0);
    wr(off(1, 0), 32'h0);
    wr(off(1, 1), 32'h0);

    // R12 R3 64-bit load without run
    wr(off(0, 1), 32'h5);
    wr(off(0, 2), 32'h2);
    wr(off(0, 0), 32'h2);
    @(negedge clk);
    rd(off(0, 4), v); chk("R12 cnt hi", 64'(v), 64'h2);
    rd(off(0, 3), v); chk("R3 cnt lo load w/o run", 64'(v), 64'h5);
    rd(off(0, 0), v); chk("R3 load bit self-clears", 64'(v), 64'h0);
    repeat (5) @(negedge clk);
    rd(off(0, 3), v); chk("R4 held while stopped", 64'(v), 64'h5);

    // R8 start delay, p=0
    wr(off(0, 2), 32'h0);
    wr(off(0, 1), 32'd10);
    wr(off(0, 0), 32'h3);
    @(negedge clk);
    rd(off(0, 3), v); chk("R3 loaded next tick", 64'(v), 64'd10);
    @(negedge clk);
    rd(off(0, 3), v); chk("R8 no count at k+2", 64'(v), 64'd10);
    @(negedge clk);
    rd(off(0, 3), v); chk("R8 first count at k+3", 64'(v), 64'd9);

    // R8 stop delay
    wr(off(0, 1), 32'd1000);
    wr(off(0, 0), 32'h3);
    repeat (10) @(negedge clk);
    wr(off(0, 0), 32'h0);
    rd(off(0, 3), v);
    repeat (2) @(negedge clk);
    rd(off(0, 3), v2); chk("R8 two more counts after stop", 64'(v - v2), 64'd2);
    repeat (8) @(negedge clk);
    rd(off(0, 3), v); chk("R8 frozen after stop", 64'(v), 64'(v2));

    // R4 all-ones free-running
    wr(off(0, 1), 32'hFFFF_FFFF);
    wr(off(0, 2), 32'hFFFF_FFFF);
    wr(off(0, 0), 32'h3);
    repeat (6) @(negedge clk);
    rd(off(0, 3), v);
    repeat (5) @(negedge clk);
    rd(off(0, 3), v2); chk("R4 falls by 5", 64'(v - v2), 64'd5);
    rd(off(0, 4), v); chk("R4 R12 hi word", 64'(v), 64'hFFFF_FFFF);
    wr(off(0, 0), 32'h0);
    wr(off(0, 2), 32'h0);

    // R11 channel 1 untouched
    rd(off(1, 3), v); chk("R11 ch1 count idle", 64'(v), 64'h0);

    // R5 R6 period sweep
    for (int p = 0; p < 3; p++)
      for (int iv = 2; iv < 6; iv++)
        measPeriod(0, p, iv);
    wr(off(0, 0), 32'h0);
    // R11 channel 1 runs alone
    measPeriod(1, 1, 3);
    measPeriod(1, 3, 2);
    wr(off(1, 0), 32'h0);
    repeat (4) @(negedge clk);
    wr(8'h04, 32'h3);

    // R7 single shot
    begin
      int t;
      wr(off(0, 1), 32'd3);
      wr(off(0, 0), 32'h83);
      waitIrq(0, t);
      chk("R7 expired", 64'(irq[0]), 64'h1);
      @(negedge clk);
      rd(off(0, 0), v); chk("R7 run bit cleared", 64'(v), 64'h80);
      wr(8'h04, 32'h1);
      repeat (30) @(negedge clk);
      rd(off(0, 3), v); chk("R7 count stays zero", 64'(v), 64'h0);
      rd(8'h04, v); chk("R7 no second expiry", 64'(v), 64'h0);
      wr(off(0, 0), 32'h83);
      waitIrq(0, t);
    end

    // R9 R10 flag clearing and masking
    chk("R10 irq with flag and enable", 64'(irq[0]), 64'h1);
    wr(8'h00, 32'h2);
    chk("R10 irq masked", 64'(irq[0]), 64'h0);
    rd(8'h04, v); chk("R10 flag kept under mask", 64'(v & 1), 64'h1);
    wr(8'h04, 32'h0);
    rd(8'h04, v); chk("R9 write 0 no effect", 64'(v & 1), 64'h1);
    wr(8'h04, 32'h1);
    rd(8'h04, v); chk("R9 write 1 clears", 64'(v & 1), 64'h0);
    wr(8'h00, 32'h3);
    chk("R10 irq low after clear", 64'(irq), 64'h0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule